// File: doc/BRIEF.md
# SPI Data FIFO Pair

This block sits between a host register interface and a serial shift engine. It holds two byte queues. The transmit queue is filled by the host and drained one byte at a time by the engine. The receive queue is filled one byte at a time by the engine and drained by the host. A host access moves either a single byte or a full 32-bit word. The choice is made by an access-width input. In word mode the least significant byte is always the first byte in time.

Each queue raises a ready flag by comparing its occupancy against a 3-bit programmable threshold. The receive queue compares its filled bytes; the transmit queue compares its free bytes. Full and empty flags are also reported. Four sticky error flags record rejected accesses. A one-shot flush request empties both queues in the following cycle and clears the error flags. The flush indicator then drops by itself.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset, both queues are empty and `flush_busy` is 0. `fifo_status` reads 12'h058: both empty bits set, transmit-ready set, all error bits clear.
- R2: With `acc_word`=0, each host write pushes `host_wr_data[7:0]` and the engine pops bytes in write order. Each host read presents the oldest receive byte zero-extended on `host_rd_data`, and bytes come out in engine push order.
- R3: With `acc_word`=1, a host write pushes four bytes, bits [7:0] first and bits [31:24] last. A host read returns the four oldest receive bytes, with the oldest in bits [7:0].
- R4: Receive-ready (`fifo_status` bit 2) is 1 exactly when the receive queue holds more bytes than `rd_thr`.
- R5: Transmit-ready (`fifo_status` bit 3) is 1 exactly when the transmit queue has more free bytes (8 minus occupancy) than `wr_thr`.
- R6: The occupancy flags sit at fixed bits: transmit-full is bit 7, transmit-empty is bit 6, receive-full is bit 5 and receive-empty is bit 4. Each queue holds 8 bytes. Bits 1:0 read 0.
- R7: A host write needing more free bytes than the transmit queue has is dropped. It sets the sticky bit 11, and the queue contents stay as they were.
- R8: An engine pop from an empty transmit queue sets the sticky bit 10.
- R9: An engine push into a full receive queue is dropped and sets the sticky bit 9.
- R10: A host read needing more bytes than the receive queue holds removes nothing and sets the sticky bit 8.
- R11: A cycle with `flush_req` high sets `flush_busy` for exactly one cycle. At the end of that cycle, both queues are empty and bits 11:8 are clear. Host and engine accesses during `flush_busy` have no effect.
- R12: A push and a pop on the same queue in the same cycle are both judged against the occupancy before that cycle, and both take effect when accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_word | input | 1 | 1: host access moves four bytes; 0: one byte |
| wr_thr | input | 3 | Transmit-ready threshold on free bytes |
| rd_thr | input | 3 | Receive-ready threshold on held bytes |
| flush_req | input | 1 | Request to empty both queues |
| flush_busy | output | 1 | High for the cycle in which the flush is applied |
| host_wr_en | input | 1 | Host write strobe into the transmit queue |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host read strobe from the receive queue |
| host_rd_data | output | 32 | Oldest receive bytes, valid before the read strobe |
| eng_tx_pop | input | 1 | Engine takes one byte from the transmit queue |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine delivers one byte to the receive queue |
| eng_rx_byte | input | 8 | Byte delivered by the engine |
| fifo_status | output | 12 | Occupancy, ready and sticky error flags |

## Verification
The bench builds the block with its default 8-byte queues and 3-bit thresholds. This small enough that every threshold value can be swept against every fill level from 0 to 8 in both queues. At each fill level, the ready, full and empty bits are compared with values computed from a byte-level model. Word mode is run with partly filled queues, so that a word access overflows or underflows by one to three bytes. The bench then checks that no byte was lost or duplicated. Same-cycle push and pop is exercised at occupancy one.

// File: rtl/spi_fifo_pkg.sv
// Package: shared constants for the SPI data FIFO pair.
// Holds the status-bit positions that the register decoder relies on and
// the host access width encoding.
package spi_fifo_pkg;

    localparam int ST_W       = 12;
    localparam int ST_TX_OVF  = 11;
    localparam int ST_TX_UNF  = 10;
    localparam int ST_RX_OVF  = 9;
    localparam int ST_RX_UNF  = 8;
    localparam int ST_TX_FULL = 7;
    localparam int ST_TX_EMP  = 6;
    localparam int ST_RX_FULL = 5;
    localparam int ST_RX_EMP  = 4;
    localparam int ST_TX_RDY  = 3;
    localparam int ST_RX_RDY  = 2;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_width_e;

endpackage

// File: rtl/spi_byte_queue.sv
// Module: spi_byte_queue
// Circular byte queue with multi-byte push and pop. A push of push_n bytes
// is accepted only if that many bytes are free; a pop of pop_n bytes only if
// that many are held. Both are judged on the occupancy before the edge.
// Assumes DEPTH is a power of two and clear has priority over all access.
module spi_byte_queue #(
    parameter int DEPTH     = 8,
    parameter int PUSH_LN   = 4,
    parameter int POP_LN    = 1,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int PUW      = $clog2(PUSH_LN + 1),
    localparam int POW      = $clog2(POP_LN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 push_req,
    input  logic [PUW-1:0]       push_n,
    input  logic [8*PUSH_LN-1:0] push_data,
    input  logic                 pop_req,
    input  logic [POW-1:0]       pop_n,
    output logic [8*POP_LN-1:0]  peek_data,
    output logic [CW-1:0]        count,
    output logic                 push_err,
    output logic                 pop_err
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] room;
    logic          push_ok;
    logic          pop_ok;

    // Acceptance decisions against the pre-edge occupancy.
    always_comb begin
        room     = CW'(DEPTH) - count;
        push_ok  = push_req && !clear && (room >= CW'(push_n));
        pop_ok   = pop_req && !clear && (count >= CW'(pop_n));
        push_err = push_req && !clear && !push_ok;
        pop_err  = pop_req && !clear && !pop_ok;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(push_n);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(pop_n);
            count <= count + (push_ok ? CW'(push_n) : CW'(0))
                           - (pop_ok  ? CW'(pop_n)  : CW'(0));
        end
    end

    // Byte storage write, lane 0 lands at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            for (int i = 0; i < PUSH_LN; i++) begin
                if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    // Oldest bytes presented to the consumer, oldest in lane 0.
    for (genvar g = 0; g < POP_LN; g++) begin : g_peek
        assign peek_data[8*g +: 8] = mem[rd_ptr + AW'(g)];
    end

    // R6: occupancy never exceeds the depth.
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11: a clear leaves the queue empty.
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R7 and R9: a rejected push with no pop leaves occupancy unchanged.
    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_err && !pop_req) |=> $stable(count));

    // R10: a rejected pop with no push leaves occupancy unchanged.
    assert_underflow_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_err && !push_req) |=> $stable(count));

endmodule

// File: rtl/spi_fifo_status.sv
// Module: spi_fifo_status
// Builds the status word from the two occupancies and thresholds, and
// keeps the four sticky error flags. Errors arrive as single-cycle pulses;
// clear (the flush cycle) wins over a new error in the same cycle.
module spi_fifo_status
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int THR_W = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CW-1:0]    tx_cnt,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             tx_ovf_ev,
    input  logic             tx_unf_ev,
    input  logic             rx_ovf_ev,
    input  logic             rx_unf_ev,
    output logic [ST_W-1:0]  status
);

    logic [3:0]    sticky;
    logic [3:0]    events;
    logic [CW-1:0] tx_free;

    assign events  = {tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev};
    assign tx_free = CW'(DEPTH) - tx_cnt;

    // Sticky error capture, cleared by reset or flush only.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sticky <= '0;
        else                 sticky <= sticky | events;
    end

    // Status word assembly.
    always_comb begin
        status             = '0;
        status[ST_TX_OVF]  = sticky[3];
        status[ST_TX_UNF]  = sticky[2];
        status[ST_RX_OVF]  = sticky[1];
        status[ST_RX_UNF]  = sticky[0];
        status[ST_TX_FULL] = (tx_cnt == CW'(DEPTH));
        status[ST_TX_EMP]  = (tx_cnt == '0);
        status[ST_RX_FULL] = (rx_cnt == CW'(DEPTH));
        status[ST_RX_EMP]  = (rx_cnt == '0);
        status[ST_TX_RDY]  = (tx_free > CW'(tx_thr));
        status[ST_RX_RDY]  = (rx_cnt > CW'(rx_thr));
    end

    // R8: error flags, once set, hold until a clear.
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((sticky & $past(sticky)) == $past(sticky)));

    // R6: a queue is never full and empty at once.
    assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_TX_FULL] && status[ST_TX_EMP]) && !(status[ST_RX_FULL] && status[ST_RX_EMP]));

endmodule

// File: rtl/spi_fifo_pair.sv
// Module: spi_fifo_pair
// Transmit and receive byte queues for an SPI shift engine, with a host side
// moving one or four bytes per access (little-endian) and an engine side
// moving one byte. A flush request is applied one cycle later and then the
// flush indicator drops by itself. Assumes host strobes are single-cycle.
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int HOST_BYTES = 4,
    parameter int THR_W      = 3,
    localparam int HW        = 8 * HOST_BYTES,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int NW        = $clog2(HOST_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_word,
    input  logic [THR_W-1:0] wr_thr,
    input  logic [THR_W-1:0] rd_thr,
    input  logic             flush_req,
    output logic             flush_busy,
    input  logic             host_wr_en,
    input  logic [HW-1:0]    host_wr_data,
    input  logic             host_rd_en,
    output logic [HW-1:0]    host_rd_data,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_byte,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_byte,
    output logic [ST_W-1:0]  fifo_status
);

    acc_width_e    acc_mode;
    logic [NW-1:0] host_n;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] rx_cnt;
    logic [HW-1:0] rx_peek;
    logic          tx_ovf_ev;
    logic          tx_unf_ev;
    logic          rx_ovf_ev;
    logic          rx_unf_ev;

    assign acc_mode = acc_width_e'(acc_word);
    assign host_n   = (acc_mode == ACC_WORD) ? NW'(HOST_BYTES) : NW'(1);

    // Flush one-shot: set by request, dropped after its single active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_busy <= 1'b0;
        else        flush_busy <= flush_req && !flush_busy;
    end

    // Transmit queue: host pushes one or four bytes, engine pops one.
    spi_byte_queue #(.DEPTH(DEPTH), .PUSH_LN(HOST_BYTES), .POP_LN(1)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush_busy),
        .push_req  (host_wr_en),
        .push_n    (host_n),
        .push_data (host_wr_data),
        .pop_req   (eng_tx_pop),
        .pop_n     (1'b1),
        .peek_data (eng_tx_byte),
        .count     (tx_cnt),
        .push_err  (tx_ovf_ev),
        .pop_err   (tx_unf_ev)
    );

    // Receive queue: engine pushes one byte, host pops one or four.
    spi_byte_queue #(.DEPTH(DEPTH), .PUSH_LN(1), .POP_LN(HOST_BYTES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush_busy),
        .push_req  (eng_rx_push),
        .push_n    (1'b1),
        .push_data (eng_rx_byte),
        .pop_req   (host_rd_en),
        .pop_n     (host_n),
        .peek_data (rx_peek),
        .count     (rx_cnt),
        .push_err  (rx_ovf_ev),
        .pop_err   (rx_unf_ev)
    );

    // Host read data: full word or lowest byte zero-extended.
    assign host_rd_data = (acc_mode == ACC_WORD) ? rx_peek : {{(HW-8){1'b0}}, rx_peek[7:0]};

    // Status word and sticky errors.
    spi_fifo_status #(.DEPTH(DEPTH), .THR_W(THR_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush_busy),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .tx_thr    (wr_thr),
        .rx_thr    (rd_thr),
        .tx_ovf_ev (tx_ovf_ev),
        .tx_unf_ev (tx_unf_ev),
        .rx_ovf_ev (rx_ovf_ev),
        .rx_unf_ev (rx_unf_ev),
        .status    (fifo_status)
    );

    // R11: the flush indicator lasts a single cycle.
    assert_flush_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> !flush_busy);

    // R11: after the flush cycle both queues are empty and errors are clear.
    assert_flush_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (fifo_status[ST_TX_EMP] && fifo_status[ST_RX_EMP]
                        && fifo_status[ST_TX_OVF:ST_RX_UNF] == 4'b0000));

endmodule

// File: tb/test_spi_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_word = 1'b0;
    logic [2:0]  wr_thr = '0;
    logic [2:0]  rd_thr = '0;
    logic        flush_req = 1'b0;
    logic        flush_busy;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic [11:0] fifo_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] wq[$];
    logic [7:0] rq[$];
    bit s_wovf, s_wund, s_rovf, s_rund;

    always #2 clk = ~clk;

    spi_fifo_pair i_spi_fifo_pair (
        .clk(clk), .rst_n(rst_n), .acc_word(acc_word), .wr_thr(wr_thr), .rd_thr(rd_thr),
        .flush_req(flush_req), .flush_busy(flush_busy),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .fifo_status(fifo_status)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_status();
        int wn = wq.size();
        int rn = rq.size();
        return {s_wovf, s_wund, s_rovf, s_rund,
                wn == 8, wn == 0, rn == 8, rn == 0,
                (8 - wn) > int'(wr_thr), rn > int'(rd_thr), 2'b00};
    endfunction

    task automatic chk_status(input string tag);
        logic [11:0] e = exp_status();
        chk(fifo_status == e, tag, 32'(fifo_status), 32'(e));
    endtask

    // One cycle of simultaneous stimulus, checked against the byte model.
    task automatic cycle(input bit hw, input logic [31:0] hwd, input bit hr,
                         input bit ep, input bit rp, input logic [7:0] rpb, input string tag);
        int n = acc_word ? 4 : 1;
        int pw = wq.size();
        int pr = rq.size();
        logic [31:0] e;
        host_wr_en = hw; host_wr_data = hwd; host_rd_en = hr;
        eng_tx_pop = ep; eng_rx_push = rp; eng_rx_byte = rpb;
        #1;
        if (ep && pw > 0) chk(eng_tx_byte == wq[0], tag, 32'(eng_tx_byte), 32'(wq[0]));
        if (hr && pr >= n) begin
            e = '0;
            for (int i = 0; i < n; i++) e[8*i +: 8] = rq[i];
            chk(host_rd_data == e, tag, host_rd_data, e);
        end
        @(posedge clk); #1;
        host_wr_en = 0; host_rd_en = 0; eng_tx_pop = 0; eng_rx_push = 0;
        if (ep) begin
            if (pw > 0) void'(wq.pop_front()); else s_wund = 1;
        end
        if (hw) begin
            if (8 - pw >= n) for (int i = 0; i < n; i++) wq.push_back(hwd[8*i +: 8]);
            else s_wovf = 1;
        end
        if (hr) begin
            if (pr >= n) for (int i = 0; i < n; i++) void'(rq.pop_front());
            else s_rund = 1;
        end
        if (rp) begin
            if (pr < 8) rq.push_back(rpb); else s_rovf = 1;
        end
        #1;
    endtask

    task automatic do_flush();
        flush_req = 1;
        @(posedge clk); #1;
        flush_req = 0;
        chk(flush_busy == 1'b1, "R11 busy set", 32'(flush_busy), 32'd1);
        @(posedge clk); #1;
        chk(flush_busy == 1'b0, "R11 busy drop", 32'(flush_busy), 32'd0);
        wq.delete(); rq.delete();
        s_wovf = 0; s_wund = 0; s_rovf = 0; s_rund = 0;
        chk_status("R11 flushed");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1: reset state
        chk(fifo_status == 12'h058, "R1 status", 32'(fifo_status), 32'h058);
        chk(flush_busy == 1'b0, "R1 flush", 32'(flush_busy), 32'd0);

        // Threshold sweep over all fill levels in byte mode (R4 R5 R6 R2).
        for (int t = 0; t < 8; t++) begin
            wr_thr = 3'(t); rd_thr = 3'(7 - t);
            do_flush();
            chk_status("R4 R5 R6 empty");
            for (int k = 0; k < 8; k++) begin
                cycle(1, 32'h0000_0000 | 32'(k * 16 + t), 0, 0, 1, 8'(8'hC0 + k + t), "R2 fill");
                chk_status("R4 R5 R6 fill");
            end
            cycle(1, 32'h0000_00EE, 0, 0, 1, 8'hEE, "R7 R9");
            chk_status("R7 R9 sticky");
            for (int k = 0; k < 8; k++) begin
                cycle(0, 0, 1, 1, 0, 0, "R2 drain");
                chk_status("R4 R5 R6 drain");
            end
            cycle(0, 0, 1, 1, 0, 0, "R8 R10");
            chk_status("R8 R10 sticky");
            cycle(0, 0, 0, 0, 0, 0, "R8 hold");
            chk_status("R8 hold");
        end

        // Word mode ordering (R3).
        wr_thr = 3; rd_thr = 3;
        do_flush();
        acc_word = 1;
        cycle(1, 32'h4433_2211, 0, 0, 0, 0, "R3 wr");
        cycle(1, 32'h8877_6655, 0, 0, 0, 0, "R3 wr");
        chk_status("R3 R6 two words");
        cycle(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R7 word");
        chk_status("R7 word overflow");
        for (int k = 0; k < 8; k++) begin
            chk(wq[0] == 8'(8'h11 * (k + 1)), "R3 model", 32'(wq[0]), 32'(8'h11 * (k + 1)));
            cycle(0, 0, 0, 1, 0, 0, "R3 tx order");
        end
        for (int k = 0; k < 8; k++) cycle(0, 0, 0, 0, 1, 8'(8'hA0 + k), "R3 rx fill");
        chk_status("R3 rx full");
        cycle(0, 0, 1, 0, 0, 0, "R3 rx word");
        cycle(0, 0, 1, 0, 0, 0, "R3 rx word");
        chk_status("R3 rx empty");

        // Partial word overflow: 5 bytes then a word write is dropped (R7).
        do_flush();
        acc_word = 0;
        for (int k = 0; k < 5; k++) cycle(1, 32'(8'h30 + k), 0, 0, 0, 0, "R7 prefill");
        acc_word = 1;
        cycle(1, 32'h9999_9999, 0, 0, 0, 0, "R7 partial");
        chk_status("R7 partial");
        for (int k = 0; k < 6; k++) cycle(0, 0, 0, 1, 0, 0, "R7 contents");
        chk_status("R7 R8 contents");

        // Partial word underflow: 3 bytes, word read removes nothing (R10).
        do_flush();
        for (int k = 0; k < 3; k++) cycle(0, 0, 0, 0, 1, 8'(8'h50 + k), "R10 prefill");
        cycle(0, 0, 1, 0, 0, 0, "R10 partial");
        chk_status("R10 partial");
        acc_word = 0;
        for (int k = 0; k < 3; k++) cycle(0, 0, 1, 0, 0, 0, "R10 contents");
        chk_status("R10 drained");

        // Same-cycle push and pop (R12).
        do_flush();
        cycle(1, 32'h5A, 0, 0, 1, 8'h6A, "R12 seed");
        cycle(1, 32'h5B, 1, 1, 1, 8'h6B, "R12 both");
        chk_status("R12 count kept");
        cycle(0, 0, 1, 1, 0, 0, "R12 next");
        chk_status("R12 empty");

        // Accesses during the flush cycle have no effect (R11).
        cycle(1, 32'h77, 0, 0, 1, 8'h78, "R11 pre");
        flush_req = 1;
        @(posedge clk); #1;
        flush_req = 0;
        host_wr_en = 1; eng_rx_push = 1; eng_tx_pop = 1; host_rd_en = 1;
        @(posedge clk); #1;
        host_wr_en = 0; eng_rx_push = 0; eng_tx_pop = 0; host_rd_en = 0;
        wq.delete(); rq.delete();
        s_wovf = 0; s_wund = 0; s_rovf = 0; s_rund = 0;
        chk_status("R11 ignored during flush");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule